// File: doc/BRIEF.md
# Quadrature Downconverter with Decimate-by-Four Filtering

This block takes a real, signed 24-bit sample stream at 192 kHz that carries a 50 kHz second IF. It shifts that IF to zero frequency and delivers a complex baseband stream at 48 kHz. A numerically controlled oscillator advances a 32-bit phase once per accepted sample. An iterative shift-and-add rotation turns that phase into cosine and sine; no stored sine table is used. Each accepted sample is multiplied by both values to form the in-phase and quadrature products.

Each product path has its own third-order cascaded integrator-comb decimator with a ratio of four. It is followed by a 15-tap symmetric correction filter that runs only at the reduced rate and flattens the decimator's passband droop. The result is rounded and saturated back to 24 bits. A single strobe marks each new I/Q pair.

The rotation unit computes the oscillator value for the *next* sample while the current interval runs. Samples therefore need a minimum spacing in clock cycles. At any practical system clock, the real 192 kHz cadence is far above that minimum.

Top module: `ddc_top`

## Requirements
- R1: While reset is asserted and after its release, before any output is produced, out_valid is 0 and out_i and out_q are 0.
- R2: Exactly one out_valid pulse is produced for every four accepted samples (in_valid high). The first comes after the fourth sample following reset. One to three further samples past a multiple of four produce no extra pulse.
- R3: out_valid goes high on the fourth rising clock edge after the edge that accepts the fourth (eighth, twelfth, ...) sample, and stays high for exactly one cycle.
- R4: out_i and out_q change only in cycles where out_valid is high.
- R5: The oscillator phase is 0 for the first sample after reset and advances by 1118481067 / 2^32 of a turn per accepted sample. I is the sample times cosine and Q is the sample times minus sine. A cosine input of amplitude A that follows this phase settles to I = A/2 and Q = 0, each within 0.5 % of A.
- R6: A sine input of amplitude A that follows the same phase settles to I = 0 and Q = -A/2, each within 0.5 % of A.
- R7: A constant input of value A is rejected: after settling, |I| and |Q| stay below A/1000.
- R8: A tone 1 kHz above the centre (phase step 1140850688 / 2^32 of a turn per sample) settles to an output magnitude sqrt(I^2 + Q^2) of A/2 within 1 %.
- R9: A full-scale cosine of amplitude 2^23 - 1 settles to a positive I of (2^23 - 1)/2 within 0.5 %, with no wrap-around.
- R10: Samples may be accepted every 25 clock cycles or more, one more than the 24 rotation steps. At exactly that spacing the oscillator is ready for each sample, and the R6 result holds unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| in_valid | input | 1 | One-cycle strobe marking an accepted input sample |
| in_data | input | 24 | Signed two's-complement IF sample |
| out_valid | output | 1 | One-cycle strobe marking a new baseband pair |
| out_i | output | 24 | Signed in-phase baseband sample |
| out_q | output | 24 | Signed quadrature baseband sample |

## Verification
The 48 kHz strobe is due on the fourth rising edge after the edge that accepts every fourth sample: mixer, integrators, combs, filter shift and filter output are one register each. The latency scenario samples out_valid at the falling edges after edges one to five and expects it only after the fourth. Filtered values reach their final level only once the integrators, combs and the 15-entry filter window have filled. Each tone scenario therefore feeds 160 samples (40 outputs), reads the last pair captured on a falling edge while the strobe is high, and compares it with the analytic amplitude A/2 within the stated tolerance. Holding of the outputs between strobes is watched on every falling edge of the run.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam int SAMP_W   = 24;   // input and output sample width
  localparam int PHASE_W  = 32;   // oscillator phase width, a full turn = 2^32
  localparam int ROT_W    = 26;   // rotation datapath width (two guard bits)
  localparam int ROT_ITER = 24;   // rotation steps per oscillator value
  localparam int DEC_RATE = 4;    // decimation ratio
  localparam int CIC_ORD  = 3;    // integrator-comb order
  localparam int FIR_TAPS = 15;   // droop-correction length
  localparam int COEF_W   = 10;   // correction coefficient width
  localparam int COEF_SH  = 8;    // correction coefficients sum to 2^COEF_SH

  // round(50000 / 192000 * 2^32)
  localparam logic [PHASE_W-1:0] NCO_INC = 32'd1118481067;

  // arctan(2^-i) scaled so that 2^32 is one full turn
  function automatic logic [PHASE_W-1:0] rot_angle(input int i);
    case (i)
      0:  rot_angle = 32'd536870912;
      1:  rot_angle = 32'd316933406;
      2:  rot_angle = 32'd167458907;
      3:  rot_angle = 32'd85004756;
      4:  rot_angle = 32'd42667331;
      5:  rot_angle = 32'd21354465;
      6:  rot_angle = 32'd10680350;
      7:  rot_angle = 32'd5340245;
      8:  rot_angle = 32'd2670163;
      9:  rot_angle = 32'd1335087;
      10: rot_angle = 32'd667544;
      11: rot_angle = 32'd333772;
      12: rot_angle = 32'd166886;
      13: rot_angle = 32'd83443;
      14: rot_angle = 32'd41722;
      15: rot_angle = 32'd20861;
      16: rot_angle = 32'd10430;
      17: rot_angle = 32'd5215;
      18: rot_angle = 32'd2608;
      19: rot_angle = 32'd1304;
      20: rot_angle = 32'd652;
      21: rot_angle = 32'd326;
      22: rot_angle = 32'd163;
      23: rot_angle = 32'd81;
      default: rot_angle = '0;
    endcase
  endfunction

  // symmetric correction taps, indexed by distance from the centre tap
  function automatic logic signed [COEF_W-1:0] comp_coef(input int k, input int taps);
    int d;
    d = k - taps / 2;
    if (d < 0) d = -d;
    case (d)
      0:  comp_coef = 10'sd302;
      1:  comp_coef = -10'sd34;
      2:  comp_coef = 10'sd18;
      3:  comp_coef = -10'sd10;
      4:  comp_coef = 10'sd6;
      5:  comp_coef = -10'sd4;
      6:  comp_coef = 10'sd2;
      7:  comp_coef = -10'sd1;
      default: comp_coef = '0;
    endcase
  endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
  import ddc_pkg::*;
#(
  parameter int RW    = ROT_W,
  parameter int ITERS = ROT_ITER,
  parameter int AMP_W = SAMP_W,
  parameter logic [PHASE_W-1:0] INC = NCO_INC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  output logic signed [RW-1:0] cos_o,
  output logic signed [RW-1:0] sin_o,
  output logic                 rdy
);

  localparam int ITW = $clog2(ITERS);
  // start vector pre-scaled by 1/1.6468 so the result peaks just below 2^(AMP_W-1)
  localparam longint X0L = ((longint'(1) << (AMP_W - 1)) * 607252) / 1000000;
  localparam logic signed [RW-1:0] X0 = RW'(X0L);

  logic [PHASE_W-1:0]        phase_r, phase_n;
  logic signed [RW-1:0]      x_r, x_n, y_r, y_n;
  logic signed [PHASE_W-1:0] z_r, z_n;
  logic                      flip_r, flip_n;
  logic [ITW-1:0]            it_r, it_n;
  logic                      busy_r, busy_n;
  logic signed [RW-1:0]      cos_n, sin_n;

  always_comb begin
    phase_n = phase_r;
    x_n     = x_r;
    y_n     = y_r;
    z_n     = z_r;
    flip_n  = flip_r;
    it_n    = it_r;
    busy_n  = busy_r;
    cos_n   = cos_o;
    sin_n   = sin_o;
    if (step) begin
      // advance, then fold the angle into [-pi/2, pi/2) and remember the flip
      phase_n = phase_r + INC;
      flip_n  = phase_n[PHASE_W-1] ^ phase_n[PHASE_W-2];
      z_n     = flip_n ? {~phase_n[PHASE_W-1], phase_n[PHASE_W-2:0]} : phase_n;
      x_n     = X0;
      y_n     = '0;
      it_n    = '0;
      busy_n  = 1'b1;
    end else if (busy_r) begin
      if (!z_r[PHASE_W-1]) begin
        x_n = x_r - (y_r >>> it_r);
        y_n = y_r + (x_r >>> it_r);
        z_n = z_r - $signed(rot_angle(int'(it_r)));
      end else begin
        x_n = x_r + (y_r >>> it_r);
        y_n = y_r - (x_r >>> it_r);
        z_n = z_r + $signed(rot_angle(int'(it_r)));
      end
      it_n = it_r + 1'b1;
      if (it_r == ITW'(ITERS - 1)) begin
        busy_n = 1'b0;
        cos_n  = flip_r ? -x_n : x_n;
        sin_n  = flip_r ? -y_n : y_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r <= '0;
      x_r     <= X0;
      y_r     <= '0;
      z_r     <= '0;
      flip_r  <= 1'b0;
      it_r    <= '0;
      busy_r  <= 1'b1;
      cos_o   <= '0;
      sin_o   <= '0;
    end else begin
      phase_r <= phase_n;
      x_r     <= x_n;
      y_r     <= y_n;
      z_r     <= z_n;
      flip_r  <= flip_n;
      it_r    <= it_n;
      busy_r  <= busy_n;
      cos_o   <= cos_n;
      sin_o   <= sin_n;
    end
  end

  assign rdy = ~busy_r;

endmodule

// File: rtl/ddc_cic.sv
module ddc_cic #(
  parameter int IW   = 24,
  parameter int RATE = 4,
  parameter int ORD  = 3,
  parameter int AW   = IW + ORD * $clog2(RATE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic signed [IW-1:0] in_d,
  output logic                 out_v,
  output logic signed [AW-1:0] out_d
);

  localparam int CNW = $clog2(RATE);

  logic signed [AW-1:0] acc_r [ORD];
  logic signed [AW-1:0] acc_n [ORD];
  logic signed [AW-1:0] dly_r [ORD];
  logic signed [AW-1:0] dly_n [ORD];
  logic signed [AW-1:0] diff  [ORD];
  logic [CNW-1:0]       cnt_r, cnt_n;
  logic                 take_r, take_n;
  logic                 ov_n;
  logic signed [AW-1:0] od_n;

  always_comb begin
    acc_n  = acc_r;
    dly_n  = dly_r;
    cnt_n  = cnt_r;
    take_n = 1'b0;
    ov_n   = 1'b0;
    od_n   = out_d;
    // comb chain on the newest integrator output
    diff[0] = acc_r[ORD-1] - dly_r[0];
    for (int k = 1; k < ORD; k++) diff[k] = diff[k-1] - dly_r[k];
    if (in_v) begin
      acc_n[0] = acc_r[0] + AW'(in_d);
      for (int k = 1; k < ORD; k++) acc_n[k] = acc_r[k] + acc_r[k-1];
      cnt_n  = cnt_r + 1'b1;
      take_n = (cnt_r == CNW'(RATE - 1));
    end
    if (take_r) begin
      dly_n[0] = acc_r[ORD-1];
      for (int k = 1; k < ORD; k++) dly_n[k] = diff[k-1];
      od_n = diff[ORD-1];
      ov_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ORD; k++) begin
        acc_r[k] <= '0;
        dly_r[k] <= '0;
      end
      cnt_r  <= '0;
      take_r <= 1'b0;
      out_v  <= 1'b0;
      out_d  <= '0;
    end else begin
      acc_r  <= acc_n;
      dly_r  <= dly_n;
      cnt_r  <= cnt_n;
      take_r <= take_n;
      out_v  <= ov_n;
      out_d  <= od_n;
    end
  end

endmodule

// File: rtl/ddc_fir.sv
module ddc_fir
  import ddc_pkg::*;
#(
  parameter int IW   = 30,
  parameter int OW   = 24,
  parameter int TAPS = FIR_TAPS,
  parameter int SH   = COEF_SH + 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic signed [IW-1:0] in_d,
  output logic                 out_v,
  output logic signed [OW-1:0] out_d
);

  localparam int SW = IW + COEF_W + $clog2(TAPS);
  localparam logic signed [SW-1:0] HI = SW'((longint'(1) << (OW - 1)) - 1);
  localparam logic signed [SW-1:0] LO = SW'(-(longint'(1) << (OW - 1)));

  logic signed [IW-1:0] tap_r [TAPS];
  logic signed [IW-1:0] tap_n [TAPS];
  logic                 go_r;
  logic signed [SW-1:0] acc, rnd, shd;
  logic signed [OW-1:0] sat, od_n;

  always_comb begin
    tap_n = tap_r;
    if (in_v) begin
      tap_n[0] = in_d;
      for (int k = 1; k < TAPS; k++) tap_n[k] = tap_r[k-1];
    end
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + SW'(tap_r[k]) * SW'(comp_coef(k, TAPS));
    rnd = acc + (SW'(1) <<< (SH - 1));
    shd = rnd >>> SH;
    if (shd > HI)      sat = OW'(HI);
    else if (shd < LO) sat = OW'(LO);
    else               sat = OW'(shd);
    od_n = go_r ? sat : out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) tap_r[k] <= '0;
      go_r  <= 1'b0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      tap_r <= tap_n;
      go_r  <= in_v;
      out_v <= go_r;
      out_d <= od_n;
    end
  end

endmodule

// File: rtl/ddc_top.sv
module ddc_top
  import ddc_pkg::*;
#(
  parameter int DW    = SAMP_W,
  parameter int RW    = ROT_W,
  parameter int ITERS = ROT_ITER,
  parameter int RATE  = DEC_RATE,
  parameter int ORD   = CIC_ORD,
  parameter int TAPS  = FIR_TAPS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);

  localparam int PW      = DW + RW;
  localparam int GAIN_SH = ORD * $clog2(RATE);
  localparam int AW      = DW + GAIN_SH;

  // asynchronous assertion, release aligned to clk
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic signed [RW-1:0] cos_w, sin_w;
  logic                 nco_rdy;

  ddc_nco #(.RW(RW), .ITERS(ITERS), .AMP_W(DW)) u_nco (
    .clk   (clk),
    .rst_n (rst_q_n),
    .step  (in_valid),
    .cos_o (cos_w),
    .sin_o (sin_w),
    .rdy   (nco_rdy)
  );

  // mixer: I = x*cos, Q = -x*sin, scaled back to DW bits
  logic signed [PW-1:0] prod_i, prod_q;
  logic signed [DW-1:0] mix_n [2];
  logic signed [DW-1:0] mix_r [2];
  logic                 mix_v;

  always_comb begin
    prod_i   = in_data * cos_w;
    prod_q   = in_data * sin_w;
    mix_n[0] = DW'(prod_i >>> (DW - 1));
    mix_n[1] = DW'(-(prod_q >>> (DW - 1)));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mix_r[0] <= '0;
      mix_r[1] <= '0;
      mix_v    <= 1'b0;
    end else begin
      mix_v <= in_valid;
      if (in_valid) begin
        mix_r[0] <= mix_n[0];
        mix_r[1] <= mix_n[1];
      end
    end
  end

  logic                 cic_v [2];
  logic signed [AW-1:0] cic_d [2];
  logic                 fir_v [2];
  logic signed [DW-1:0] fir_d [2];

  for (genvar p = 0; p < 2; p++) begin : g_path
    ddc_cic #(.IW(DW), .RATE(RATE), .ORD(ORD), .AW(AW)) u_cic (
      .clk   (clk),
      .rst_n (rst_q_n),
      .in_v  (mix_v),
      .in_d  (mix_r[p]),
      .out_v (cic_v[p]),
      .out_d (cic_d[p])
    );
    ddc_fir #(.IW(AW), .OW(DW), .TAPS(TAPS), .SH(COEF_SH + GAIN_SH)) u_fir (
      .clk   (clk),
      .rst_n (rst_q_n),
      .in_v  (cic_v[p]),
      .in_d  (cic_d[p]),
      .out_v (fir_v[p]),
      .out_d (fir_d[p])
    );
  end

  assign out_valid = fir_v[0] & fir_v[1];
  assign out_i     = fir_d[0];
  assign out_q     = fir_d[1];

endmodule

// File: rtl/ddc_chk.sv
module ddc_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          nco_rdy,
  input logic          out_valid,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q
);

  // R10
  nco_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> nco_rdy);

  // R3
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 5));

  // R3
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_i) || !$stable(out_q)) |-> out_valid);

endmodule

bind ddc_top ddc_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .nco_rdy   (nco_rdy),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_ddc_top.sv
module tb_ddc_top;

  localparam longint INC_C  = 64'd1118481067;
  localparam longint INC_UP = 64'd1140850688;
  localparam real    TWO_PI = 6.283185307179586;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [23:0] in_data;
  logic               out_valid;
  logic signed [23:0] out_i;
  logic signed [23:0] out_q;

  int n_chk, n_bad, n_out, n_smp, hold_bad;
  logic signed [23:0] last_i, last_q, hold_i, hold_q;

  ddc_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // capture and hold monitor on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_out  = n_out + 1;
        last_i = out_i;
        last_q = out_q;
      end else if (out_i !== hold_i || out_q !== hold_q) begin
        hold_bad = hold_bad + 1;
      end
      hold_i = out_i;
      hold_q = out_q;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint labs(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic signed [23:0] tone(input int n, input longint inc,
                                              input real amp, input bit use_sin);
    longint p;
    real th, v;
    p  = (longint'(n) * inc) & 64'hFFFF_FFFF;
    th = TWO_PI * real'(p) / 4294967296.0;
    v  = use_sin ? amp * $sin(th) : amp * $cos(th);
    return 24'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
    rst_n    = 1'b0;
    n_out    = 0;
    n_smp    = 0;
    hold_i   = '0;
    hold_q   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic send(input logic signed [23:0] x, input int gap);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
    n_smp++;
  endtask

  // R1: reset values
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    chk(out_i == 0, "R1 out_i in reset", longint'(out_i), 0);
    chk(out_q == 0, "R1 out_q in reset", longint'(out_q), 0);
    do_reset();
    chk(out_valid == 1'b0, "R1 valid after release", longint'(out_valid), 0);
    chk(out_i == 0 && out_q == 0, "R1 outputs after release", longint'(out_i), 0);
  endtask

  // R2 and R3: first output timing and pulse width
  task automatic t_latency();
    do_reset();
    for (int n = 0; n < 3; n++) send(24'sd1000, 32);
    chk(n_out == 0, "R2 no output before fourth sample", n_out, 0);
    in_valid = 1'b1;
    in_data  = 24'sd1000;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(out_valid == (k == 4), $sformatf("R3 strobe %0d edges after accept", k),
          longint'(out_valid), longint'(k == 4));
    end
    repeat (26) @(negedge clk);
    chk(n_out == 1, "R2 one output after four samples", n_out, 1);
  endtask

  // R2: cadence over a long run
  task automatic t_cadence();
    do_reset();
    for (int n = 0; n < 203; n++) send(tone(n, INC_C, 1.0e6, 1'b0), 32);
    chk(n_out == 50, "R2 203 samples give 50 outputs", n_out, 50);
    send(24'sd0, 32);
    chk(n_out == 51, "R2 204 samples give 51 outputs", n_out, 51);
  endtask

  // R5: in-phase cosine
  task automatic t_cos();
    longint a;
    a = 64'd4194304;
    do_reset();
    for (int n = 0; n < 160; n++) send(tone(n, INC_C, real'(a), 1'b0), 32);
    chk(labs(longint'(last_i) - a / 2) <= a / 200, "R5 cosine I", longint'(last_i), a / 2);
    chk(labs(longint'(last_q)) <= a / 200, "R5 cosine Q", longint'(last_q), 0);
  endtask

  // R6 and R10: sine at the minimum spacing of 25 cycles
  task automatic t_sin();
    longint a;
    a = 64'd4194304;
    do_reset();
    for (int n = 0; n < 160; n++) send(tone(n, INC_C, real'(a), 1'b1), 25);
    chk(labs(longint'(last_i)) <= a / 200, "R6 R10 sine I", longint'(last_i), 0);
    chk(labs(longint'(last_q) + a / 2) <= a / 200, "R6 R10 sine Q", longint'(last_q), -a / 2);
    chk(n_out == 40, "R10 output count at minimum spacing", n_out, 40);
  endtask

  // R7: constant input rejected
  task automatic t_dc();
    longint a;
    a = 64'd4194304;
    do_reset();
    for (int n = 0; n < 160; n++) send(24'(a), 32);
    chk(labs(longint'(last_i)) < a / 1000, "R7 constant input I", longint'(last_i), 0);
    chk(labs(longint'(last_q)) < a / 1000, "R7 constant input Q", longint'(last_q), 0);
  endtask

  // R8: tone 1 kHz above centre
  task automatic t_offset();
    longint a;
    real m;
    a = 64'd4194304;
    do_reset();
    for (int n = 0; n < 160; n++) send(tone(n, INC_UP, real'(a), 1'b0), 32);
    m = $sqrt(real'(last_i) * real'(last_i) + real'(last_q) * real'(last_q));
    chk(labs(longint'($rtoi(m)) - a / 2) <= a / 200, "R8 offset tone magnitude",
        longint'($rtoi(m)), a / 2);
  endtask

  // R9: full-scale cosine
  task automatic t_full();
    longint a;
    a = 64'd8388607;
    do_reset();
    for (int n = 0; n < 160; n++) send(tone(n, INC_C, real'(a), 1'b0), 32);
    chk(last_i > 0 && labs(longint'(last_i) - a / 2) <= a / 200, "R9 full-scale I",
        longint'(last_i), a / 2);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; n_out = 0; n_smp = 0; hold_bad = 0;
    last_i = '0; last_q = '0; hold_i = '0; hold_q = '0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    t_reset();
    t_latency();
    t_cadence();
    t_cos();
    t_sin();
    t_dc();
    t_offset();
    t_full();
    // R4: outputs held between strobes over the whole run
    chk(hold_bad == 0, "R4 outputs held between strobes", hold_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_smp, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule